// File: doc/BRIEF.md
# Masked Vector Move Writeback Unit

This unit forms the final result of a packed vector move built from 32-bit lanes. It receives a source vector, the current contents of the destination and a 16-bit lane mask. It also receives a set of fields that an earlier decode stage has already extracted: the prefix class, a length code, a masking enable, a zero-versus-merge flag, a direction bit and a 4-bit reserved specifier. The result appears one clock after the request. In the register/load direction the result is the new 512-bit destination register. In the store direction the result is the merged memory image plus one byte enable per byte.

Each lane that lies inside the selected vector length is either copied from the source or left unselected. An unselected lane is zeroed or keeps its old value, depending on the mode. What happens to the lanes above the vector length depends on the prefix class: the legacy class keeps them, and the two newer classes clear them. A store never clears anything. A reserved specifier that is not all ones under a newer prefix class, or a length that the class does not support, raises an invalid-opcode fault. A fault suppresses every write.

Top module: `vmove_wb`

## Requirements
- R1: After reset, and before the first request, `out_valid`, `out_fault`, `dest_vec` and `byte_en` are all zero.
- R2: A request taken with `in_valid` high produces `out_valid` high for exactly one cycle, on the next rising edge, with all results of that request. `out_valid` is low in every other cycle.
- R3: Lane j (bits 32j+31:32j) is selected when `enc_class`=2 (extended prefix), `mask_en`=1 and `lane_mask[j]`=1. Under `enc_class` 0 (legacy) or 1 (compact prefix), or when `mask_en`=0, every lane inside the length is selected and the mask has no effect.
- R4: In the load form (`is_store`=0, opcode byte 0x10), a selected lane inside the length takes the source lane. An unselected lane inside the length takes zero when `zero_mode`=1 and keeps the old lane when `zero_mode`=0.
- R5: `vl_sel` 0, 1 and 2 give 4, 8 and 16 lanes (128, 256 and 512 bits). The legacy class always uses 4 lanes and ignores `vl_sel`.
- R6: In a legacy load, lanes above the length keep the old destination value.
- R7: In a load under the compact or extended class, every lane above the length is cleared to zero.
- R8: In the store form (`is_store`=1, opcode byte 0x11), a lane is written only when it is inside the length and selected. `byte_en[4j+3:4j]` is 4'b1111 for a written lane and 4'b0000 otherwise. Every unwritten lane outputs the old value, whatever `zero_mode` is.
- R9: In the load form, `byte_en` is all zero.
- R10: `out_fault` is 1 in each of these cases: `spare_field` is not 4'b1111 under class 1 or 2; `enc_class` is 3; `vl_sel` is 3 under class 1 or 2; `vl_sel` is 2 under class 1. The legacy class never checks `spare_field`. On a fault, `dest_vec` equals `old_vec` and `byte_en` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 512 | Source vector |
| old_vec | input | 512 | Current destination contents (register or memory image) |
| lane_mask | input | 16 | Per-lane write mask |
| enc_class | input | 2 | 0 legacy, 1 compact prefix, 2 extended prefix, 3 undefined |
| vl_sel | input | 2 | Length code: 0=128, 1=256, 2=512 bits |
| mask_en | input | 1 | Writemask in use (extended class only) |
| zero_mode | input | 1 | 1 zeroes unselected lanes in the load form |
| is_store | input | 1 | 0 register/load direction, 1 store direction |
| spare_field | input | 4 | Reserved specifier, must be 4'b1111 under classes 1 and 2 |
| out_valid | output | 1 | One-cycle result strobe |
| out_fault | output | 1 | Invalid-opcode fault |
| out_store | output | 1 | Registered direction of the result |
| dest_vec | output | 512 | New destination value or merged store image |
| byte_en | output | 64 | Store byte enables |

## Verification
The embedded assertions check, on every request, that legacy loads keep the lanes above the length and that loads under the newer classes clear them. Every cycle they also check that a store never enables a lane beyond the length, that byte enables come in whole-lane groups, that loads and faults raise no enables, and that the result strobe only follows a request. The exact lane values under merge and zero masking, the decoding of each length code, and the full set of fault cases are shown only by the bench's scenarios. There, directed corner cases and random requests are compared with a reference model.

// File: rtl/vmwb_pkg.sv
package vmwb_pkg;

   typedef enum logic [1:0] {
      ENC_LEGACY   = 2'd0,
      ENC_COMPACT  = 2'd1,
      ENC_EXTENDED = 2'd2,
      ENC_UNDEF    = 2'd3
   } enc_class_e;

   typedef enum logic [1:0] {
      VL_128  = 2'd0,
      VL_256  = 2'd1,
      VL_512  = 2'd2,
      VL_BAD  = 2'd3
   } vl_code_e;

   localparam logic [3:0] SPARE_OK = 4'b1111;

endpackage

// File: rtl/mvwb_decode.sv
module mvwb_decode
   import vmwb_pkg::*;
#(
   parameter int LANE_W = 32,
   parameter int MAX_VL = 512,
   localparam int NL    = MAX_VL / LANE_W,
   localparam int CW    = $clog2(NL + 1)
) (
   input  logic [1:0]    enc_class,
   input  logic [1:0]    vl_sel,
   input  logic [3:0]    spare_field,
   input  logic          mask_en,
   input  logic [NL-1:0] lane_mask,
   output logic          fault,
   output logic          clr_upper,
   output logic [NL-1:0] lane_in,
   output logic [NL-1:0] lane_pick
);

   localparam int N128 = 128 / LANE_W;
   localparam int N256 = 256 / LANE_W;
   localparam int N512 = 512 / LANE_W;

   enc_class_e      ec;
   vl_code_e        vc;
   logic [CW-1:0]   nlanes;
   logic            spare_bad;

   assign ec        = enc_class_e'(enc_class);
   assign vc        = vl_code_e'(vl_sel);
   assign spare_bad = (spare_field != SPARE_OK);

   always_comb begin
      fault  = 1'b0;
      nlanes = CW'(N128);
      unique case (ec)
         ENC_LEGACY: begin
            fault  = 1'b0;
            nlanes = CW'(N128);
         end
         ENC_COMPACT: begin
            fault  = spare_bad || (vc == VL_512) || (vc == VL_BAD);
            nlanes = (vc == VL_256) ? CW'(N256) : CW'(N128);
         end
         ENC_EXTENDED: begin
            fault = spare_bad || (vc == VL_BAD);
            case (vc)
               VL_256:  nlanes = CW'(N256);
               VL_512:  nlanes = CW'(N512);
               default: nlanes = CW'(N128);
            endcase
         end
         default: begin
            fault  = 1'b1;
            nlanes = CW'(N128);
         end
      endcase
   end

   assign clr_upper = (ec != ENC_LEGACY);

   for (genvar j = 0; j < NL; j++) begin : g_lane_dec
      assign lane_in[j]   = (CW'(j) < nlanes);
      assign lane_pick[j] = ((ec == ENC_EXTENDED) && mask_en) ? lane_mask[j] : 1'b1;
   end

endmodule

// File: rtl/mvwb_lane.sv
module mvwb_lane #(
   parameter int LANE_W = 32
) (
   input  logic [LANE_W-1:0] src_lane,
   input  logic [LANE_W-1:0] old_lane,
   input  logic              in_len,
   input  logic              pick,
   input  logic              zero_mode,
   input  logic              is_store,
   input  logic              clr_upper,
   input  logic              fault,
   output logic [LANE_W-1:0] data,
   output logic              wr
);

   always_comb begin
      wr   = 1'b0;
      data = old_lane;
      if (!fault) begin
         if (is_store) begin
            if (in_len && pick) begin
               data = src_lane;
               wr   = 1'b1;
            end
         end else if (in_len) begin
            if (pick)
               data = src_lane;
            else if (zero_mode)
               data = '0;
         end else if (clr_upper) begin
            data = '0;
         end
      end
   end

endmodule

// File: rtl/vmove_wb.sv
module vmove_wb
   import vmwb_pkg::*;
#(
   parameter int LANE_W = 32,
   parameter int MAX_VL = 512,
   localparam int NL    = MAX_VL / LANE_W,
   localparam int BPL   = LANE_W / 8,
   localparam int NB    = MAX_VL / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [MAX_VL-1:0] src_vec,
   input  logic [MAX_VL-1:0] old_vec,
   input  logic [NL-1:0]     lane_mask,
   input  logic [1:0]        enc_class,
   input  logic [1:0]        vl_sel,
   input  logic              mask_en,
   input  logic              zero_mode,
   input  logic              is_store,
   input  logic [3:0]        spare_field,
   output logic              out_valid,
   output logic              out_fault,
   output logic              out_store,
   output logic [MAX_VL-1:0] dest_vec,
   output logic [NB-1:0]     byte_en
);

   if (MAX_VL != 512) begin : g_chk_vl
      $error("vmove_wb: MAX_VL must be 512");
   end
   if ((LANE_W % 8) != 0 || (128 % LANE_W) != 0) begin : g_chk_lane
      $error("vmove_wb: LANE_W must be a byte multiple dividing 128");
   end

   logic              dec_fault;
   logic              dec_clr;
   logic [NL-1:0]     lane_in;
   logic [NL-1:0]     lane_pick;
   logic [NL-1:0]     lane_wr;
   logic [MAX_VL-1:0] nxt_data;
   logic [NB-1:0]     nxt_be;

   mvwb_decode #(
      .LANE_W (LANE_W),
      .MAX_VL (MAX_VL)
   ) i_decode (
      .enc_class   (enc_class),
      .vl_sel      (vl_sel),
      .spare_field (spare_field),
      .mask_en     (mask_en),
      .lane_mask   (lane_mask),
      .fault       (dec_fault),
      .clr_upper   (dec_clr),
      .lane_in     (lane_in),
      .lane_pick   (lane_pick)
   );

   for (genvar j = 0; j < NL; j++) begin : g_lane
      mvwb_lane #(
         .LANE_W (LANE_W)
      ) i_lane (
         .src_lane  (src_vec[j*LANE_W +: LANE_W]),
         .old_lane  (old_vec[j*LANE_W +: LANE_W]),
         .in_len    (lane_in[j]),
         .pick      (lane_pick[j]),
         .zero_mode (zero_mode),
         .is_store  (is_store),
         .clr_upper (dec_clr),
         .fault     (dec_fault),
         .data      (nxt_data[j*LANE_W +: LANE_W]),
         .wr        (lane_wr[j])
      );
      assign nxt_be[j*BPL +: BPL] = {BPL{lane_wr[j]}};

      // legacy loads keep lanes beyond the length
      assert_legacy_keep_R6 : assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !is_store && !lane_in[j] && enc_class == 2'd0)
         |-> (nxt_data[j*LANE_W +: LANE_W] == old_vec[j*LANE_W +: LANE_W]));

      // newer classes clear lanes beyond the length on loads
      assert_upper_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !is_store && !dec_fault && !lane_in[j]
          && (enc_class == 2'd1 || enc_class == 2'd2))
         |-> (nxt_data[j*LANE_W +: LANE_W] == '0));

      // byte enables come in whole-lane groups
      assert_be_group_R8 : assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> ($countones(byte_en[j*BPL +: BPL]) == 0
                        || $countones(byte_en[j*BPL +: BPL]) == BPL));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_fault <= 1'b0;
         out_store <= 1'b0;
         dest_vec  <= '0;
         byte_en   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_fault <= dec_fault;
            out_store <= is_store;
            dest_vec  <= nxt_data;
            byte_en   <= nxt_be;
         end
      end
   end

   // no store enable beyond the selected length
   assert_store_bound_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ((lane_wr & ~lane_in) == '0));

   // loads never raise byte enables
   assert_load_noen_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_store) |-> (byte_en == '0));

   // a fault suppresses all writes
   assert_fault_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault) |-> (byte_en == '0));

   // result strobe only follows a request
   assert_strobe_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

endmodule

// File: tb/test_vmove_wb.sv
module test_vmove_wb;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [511:0]  src_vec = '0;
   logic [511:0]  old_vec = '0;
   logic [15:0]   lane_mask = '0;
   logic [1:0]    enc_class = '0;
   logic [1:0]    vl_sel = '0;
   logic          mask_en = 1'b0;
   logic          zero_mode = 1'b0;
   logic          is_store = 1'b0;
   logic [3:0]    spare_field = 4'hF;
   logic          out_valid, out_fault, out_store;
   logic [511:0]  dest_vec;
   logic [63:0]   byte_en;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   vmove_wb i_vmove_wb (
      .clk, .rst_n, .in_valid, .src_vec, .old_vec, .lane_mask, .enc_class,
      .vl_sel, .mask_en, .zero_mode, .is_store, .spare_field,
      .out_valid, .out_fault, .out_store, .dest_vec, .byte_en
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [511:0] act, input logic [511:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void ref_calc(output logic [511:0] d, output logic [63:0] be,
                                    output logic f);
      int nl;
      bit spare_bad;
      spare_bad = (spare_field != 4'hF);
      case (enc_class)
         2'd0: begin f = 1'b0; nl = 4; end
         2'd1: begin f = spare_bad || vl_sel >= 2; nl = (vl_sel == 1) ? 8 : 4; end
         2'd2: begin f = spare_bad || vl_sel == 3;
                     nl = (vl_sel == 0) ? 4 : (vl_sel == 1) ? 8 : 16; end
         default: begin f = 1'b1; nl = 4; end
      endcase
      d  = old_vec;
      be = '0;
      if (!f) begin
         for (int j = 0; j < 16; j++) begin
            bit inl, sel;
            inl = (j < nl);
            sel = (enc_class == 2'd2 && mask_en) ? lane_mask[j] : 1'b1;
            if (is_store) begin
               if (inl && sel) begin
                  d[j*32 +: 32] = src_vec[j*32 +: 32];
                  be[j*4 +: 4]  = 4'hF;
               end
            end else if (inl) begin
               if (sel) d[j*32 +: 32] = src_vec[j*32 +: 32];
               else if (zero_mode) d[j*32 +: 32] = '0;
            end else if (enc_class != 2'd0) begin
               d[j*32 +: 32] = '0;
            end
         end
      end
   endfunction

   // called at a falling edge; results are sampled one falling edge later
   task automatic do_op(input string req);
      logic [511:0] ed;
      logic [63:0]  eb;
      logic         ef;
      ref_calc(ed, eb, ef);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R2", "out_valid", 512'(out_valid), 512'(1));
      chk(out_fault == ef, "R10", "out_fault", 512'(out_fault), 512'(ef));
      chk(dest_vec == ed, req, "dest_vec", dest_vec, ed);
      chk(byte_en == eb, is_store ? "R8" : "R9", "byte_en", 512'(byte_en), 512'(eb));
   endtask

   function automatic logic [511:0] rnd512();
      logic [511:0] v;
      for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic setup(input logic [1:0] ec, input logic [1:0] vl, input logic [3:0] sp,
                        input logic me, input logic [15:0] m, input logic zm, input logic st);
      enc_class = ec; vl_sel = vl; spare_field = sp; mask_en = me;
      lane_mask = m; zero_mode = zm; is_store = st;
      src_vec = rnd512(); old_vec = rnd512();
   endtask

   initial begin
      void'($urandom(32'h1CE5_0B0E));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid == 1'b0 && out_fault == 1'b0, "R1", "flags", 512'({out_valid, out_fault}), '0);
      chk(dest_vec == '0, "R1", "dest_vec", dest_vec, '0);
      chk(byte_en == '0, "R1", "byte_en", 512'(byte_en), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R2", "idle out_valid", 512'(out_valid), '0);

      // R3 R4 R5: extended 512 merge then zero masking
      setup(2'd2, 2'd2, 4'hF, 1'b1, 16'hA5A5, 1'b0, 1'b0); do_op("R4");
      setup(2'd2, 2'd2, 4'hF, 1'b1, 16'h3C0F, 1'b1, 1'b0); do_op("R4");
      // R7 R5: extended 128 load clears upper lanes
      setup(2'd2, 2'd0, 4'hF, 1'b1, 16'hFFF6, 1'b1, 1'b0); do_op("R7");
      // R3: compact class ignores the mask, R7 upper clear at 256
      setup(2'd1, 2'd1, 4'hF, 1'b1, 16'h0000, 1'b1, 1'b0); do_op("R3");
      // R6 R5: legacy ignores vl_sel and spare field, keeps upper lanes
      setup(2'd0, 2'd2, 4'h0, 1'b1, 16'h0000, 1'b1, 1'b0); do_op("R6");
      // R8: masked store at 256 keeps unselected lanes despite zero_mode
      setup(2'd2, 2'd1, 4'hF, 1'b1, 16'hF0F3, 1'b1, 1'b1); do_op("R8");
      // R8: legacy store writes low 128 bits only
      setup(2'd0, 2'd2, 4'hF, 1'b0, 16'h0000, 1'b0, 1'b1); do_op("R8");
      // R10: fault cases
      setup(2'd2, 2'd2, 4'h7, 1'b0, 16'hFFFF, 1'b0, 1'b0); do_op("R10");
      setup(2'd1, 2'd2, 4'hF, 1'b0, 16'hFFFF, 1'b0, 1'b1); do_op("R10");
      setup(2'd3, 2'd0, 4'hF, 1'b0, 16'hFFFF, 1'b0, 1'b0); do_op("R10");
      setup(2'd2, 2'd3, 4'hF, 1'b0, 16'hFFFF, 1'b0, 1'b1); do_op("R10");
      @(negedge clk);
      chk(out_valid == 1'b0, "R2", "strobe drop", 512'(out_valid), '0);

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [1:0] ec;
         ec = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
         setup(ec, 2'($urandom), ($urandom % 6 == 0) ? 4'($urandom) : 4'hF,
               1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
         if ($urandom % 4 == 0) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R2", "gap out_valid", 512'(out_valid), '0);
         end
         do_op(is_store ? "R8" : (ec == 2'd0 ? "R6" : "R7"));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule